// File: doc/BRIEF.md
# Sleep Wake-Up Controller

This block manages the low-power idle state of a small processor. A halt request from the core puts it to sleep. While asleep it watches four wake sources: an external reset request, a watchdog overflow, interrupt request flags, and falling edges on two 8-bit pin ports, each pin having its own wake-enable bit. When a source fires, the block leaves sleep and tells the core which resume action to take. The actions are a full reset, a watchdog-style partial reset of the program counter and stack pointer, a continue at the instruction after the halt, or a jump to the interrupt vector.

The block also keeps two status flags that software reads to learn why the processor woke: a power-down flag that is set by the halt, and a time-out flag that is set by a watchdog wake. Interrupt flags that are already pending when sleep starts are masked, so they cannot wake the processor. Pin inputs pass through a two-flop synchronizer before edge detection. A pin that is already low when sleep starts therefore does not count as an edge.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A `halt_req` pulse while awake and with no `ext_rst` raises `asleep` on the next clock edge and sets `pd_flag`. A `halt_req` while already asleep has no effect.
- R2: An `ext_rst` while asleep wakes the block with cause bit 0 and action bit 0 (full reset), and clears both `to_flag` and `pd_flag`. An `ext_rst` while awake also clears both flags.
- R3: A `wdt_ovf` while asleep wakes the block with cause bit 1 and action bit 1 (partial reset). It sets `to_flag` and leaves `pd_flag` unchanged.
- R4: A high-to-low change on an enabled pin of either port wakes the block with cause bit 3 and action bit 2 (continue after halt). `wake_valid` rises on the third clock edge after the pin changes.
- R5: These cause no wake: a falling edge on a pin whose enable bit is 0, a rising edge, and a pin that is already low when sleep is entered.
- R6: An interrupt wake (cause bit 2) whose waking flag has its enable set gives action bit 3 (vector) when `stack_full` is 0.
- R7: An interrupt wake whose waking flags are all disabled, or that occurs while `stack_full` is 1, gives action bit 2 (continue after halt).
- R8: An interrupt flag that is already set on the cycle sleep is entered cannot wake the block during that sleep. Other interrupt flags can still wake it.
- R9: When several wake sources fire in the same cycle, priority runs from external reset, to watchdog overflow, to interrupt, to pin edge.
- R10: A wake lowers `asleep` and pulses `wake_valid` for exactly one cycle. `wake_cause` and `wake_act` are each one-hot while `wake_valid` is high.
- R11: `clr_wdt` while awake clears `pd_flag` and `to_flag`. Power-up reset (`rst_n` low) clears every flag and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| halt_req | input | 1 | Halt executed by the core |
| clr_wdt | input | 1 | Clear-watchdog command |
| ext_rst | input | 1 | External reset request |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| pa_pin | input | 8 | Port A pin levels (asynchronous) |
| pc_pin | input | 8 | Port C pin levels (asynchronous) |
| pa_wken | input | 8 | Port A per-pin wake enables |
| pc_wken | input | 8 | Port C per-pin wake enables |
| irq_flag | input | 4 | Interrupt request flags |
| irq_en | input | 4 | Interrupt enables |
| stack_full | input | 1 | Return stack has no free level |
| asleep | output | 1 | High while in sleep |
| wake_valid | output | 1 | One-cycle strobe on wake |
| wake_cause | output | 4 | One-hot cause: 0 ext, 1 wdt, 2 irq, 3 pin |
| wake_act | output | 4 | One-hot action: 0 full reset, 1 partial reset, 2 continue, 3 vector |
| to_flag | output | 1 | Time-out status |
| pd_flag | output | 1 | Power-down status |

## Verification
The arbiter must settle collisions. A watchdog overflow can arrive in the same cycle as an interrupt request, or as an external reset, or as a falling pin edge. The bench raises these sources together on a single clock edge while the block sleeps. It then checks that only the higher-priority cause and its action appear on the strobe. It also checks that the time-out flag follows the cause that won, not a cause that lost.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int NCAUSE = 4;
  localparam int C_EXT = 0;
  localparam int C_WDT = 1;
  localparam int C_IRQ = 2;
  localparam int C_PIN = 3;
  localparam int A_FULL = 0;
  localparam int A_PART = 1;
  localparam int A_CONT = 2;
  localparam int A_VEC  = 3;

  typedef logic [NCAUSE-1:0] onehot_t;

  // priority: ext > wdt > irq > pin
  function automatic onehot_t pick_cause(logic ext, logic wdt, logic irq, logic pin);
    onehot_t c = '0;
    if (ext)      c[C_EXT] = 1'b1;
    else if (wdt) c[C_WDT] = 1'b1;
    else if (irq) c[C_IRQ] = 1'b1;
    else if (pin) c[C_PIN] = 1'b1;
    return c;
  endfunction

  function automatic onehot_t pick_act(onehot_t c, logic vec_ok);
    onehot_t a = '0;
    if (c[C_EXT])      a[A_FULL] = 1'b1;
    else if (c[C_WDT]) a[A_PART] = 1'b1;
    else if (c[C_IRQ]) a[vec_ok ? A_VEC : A_CONT] = 1'b1;
    else if (c[C_PIN]) a[A_CONT] = 1'b1;
    return a;
  endfunction
endpackage

// File: rtl/slp_pin_edge.sv
module slp_pin_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] wken,
  output logic         fall_hit
);
  logic [W-1:0] s1, s2, prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '1;
      s2   <= '1;
      prev <= '1;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= s2;
    end
  end
  assign fall_hit = |(prev & ~s2 & wken);
endmodule

// File: rtl/slp_flags.sv
module slp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic full_rst,
  input  logic halt_enter,
  input  logic wdt_wake,
  input  logic clr_wdt,
  output logic to_flag,
  output logic pd_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_flag <= 1'b0;
      pd_flag <= 1'b0;
    end else begin
      if (full_rst)        to_flag <= 1'b0;
      else if (wdt_wake)   to_flag <= 1'b1;
      else if (clr_wdt)    to_flag <= 1'b0;
      if (full_rst)        pd_flag <= 1'b0;
      else if (halt_enter) pd_flag <= 1'b1;
      else if (clr_wdt)    pd_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int PW   = 8,
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            clr_wdt,
  input  logic            ext_rst,
  input  logic            wdt_ovf,
  input  logic [PW-1:0]   pa_pin,
  input  logic [PW-1:0]   pc_pin,
  input  logic [PW-1:0]   pa_wken,
  input  logic [PW-1:0]   pc_wken,
  input  logic [NIRQ-1:0] irq_flag,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            stack_full,
  output logic            asleep,
  output logic            wake_valid,
  output logic [3:0]      wake_cause,
  output logic [3:0]      wake_act,
  output logic            to_flag,
  output logic            pd_flag
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] port_hit;
  logic [PW-1:0]    pins  [NPORT];
  logic [PW-1:0]    wkens [NPORT];
  assign pins[0]  = pa_pin;
  assign pins[1]  = pc_pin;
  assign wkens[0] = pa_wken;
  assign wkens[1] = pc_wken;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    slp_pin_edge #(.W(PW)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pins[p]), .wken(wkens[p]),
      .fall_hit(port_hit[p])
    );
  end

  // named internal events
  logic            halt_enter, ev_ext, ev_wdt, ev_irq, ev_pin, wake_now, vec_ok;
  logic [NIRQ-1:0] blk_mask, irq_live;
  onehot_t         cause_nxt, act_nxt;

  assign halt_enter = halt_req && !asleep && !ext_rst;
  assign irq_live   = irq_flag & ~blk_mask;
  assign ev_ext     = asleep && ext_rst;
  assign ev_wdt     = asleep && wdt_ovf;
  assign ev_irq     = asleep && (|irq_live);
  assign ev_pin     = asleep && (|port_hit);
  assign wake_now   = ev_ext || ev_wdt || ev_irq || ev_pin;
  assign vec_ok     = (|(irq_live & irq_en)) && !stack_full;
  assign cause_nxt  = pick_cause(ev_ext, ev_wdt, ev_irq, ev_pin);
  assign act_nxt    = pick_act(cause_nxt, vec_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      blk_mask   <= '0;
      wake_valid <= 1'b0;
      wake_cause <= '0;
      wake_act   <= '0;
    end else begin
      wake_valid <= wake_now;
      if (halt_enter) begin
        asleep   <= 1'b1;
        blk_mask <= irq_flag;
      end else if (wake_now) begin
        asleep   <= 1'b0;
      end
      if (wake_now) begin
        wake_cause <= cause_nxt;
        wake_act   <= act_nxt;
      end else begin
        wake_cause <= '0;
        wake_act   <= '0;
      end
    end
  end

  slp_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .full_rst(ext_rst),
    .halt_enter(halt_enter),
    .wdt_wake(ev_wdt && !ev_ext),
    .clr_wdt(clr_wdt),
    .to_flag(to_flag), .pd_flag(pd_flag)
  );
endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       clr_wdt,
  input logic       ext_rst,
  input logic       asleep,
  input logic       wake_valid,
  input logic [3:0] wake_cause,
  input logic [3:0] wake_act,
  input logic       to_flag,
  input logic       pd_flag
);
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> ($countones(wake_cause) == 1 && $countones(wake_act) == 1));
  a_r10_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> ($past(asleep) && !asleep));
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !wake_valid);
  a_r1_enter_pd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> pd_flag);
  a_r2_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && wake_cause[0]) |-> (wake_act[0] && !to_flag && !pd_flag));
  a_r3_part: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && wake_cause[1]) |-> (wake_act[1] && to_flag && pd_flag));
  a_r4_pin_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && wake_cause[3]) |-> wake_act[2]);
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt && !asleep && !halt_req) |=> (!to_flag && !pd_flag));
endmodule

bind slp_wake_ctrl slp_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clr_wdt(clr_wdt),
  .ext_rst(ext_rst), .asleep(asleep), .wake_valid(wake_valid),
  .wake_cause(wake_cause), .wake_act(wake_act),
  .to_flag(to_flag), .pd_flag(pd_flag)
);

// File: tb/tb_slp_wake_ctrl.sv
`timescale 1ns/1ps
module tb_slp_wake_ctrl;
  logic clk = 0, rst_n = 0;
  logic halt_req = 0, clr_wdt = 0, ext_rst = 0, wdt_ovf = 0, stack_full = 0;
  logic [7:0] pa_pin = '1, pc_pin = '1, pa_wken = '0, pc_wken = '0;
  logic [3:0] irq_flag = '0, irq_en = '0;
  logic asleep, wake_valid, to_flag, pd_flag;
  logic [3:0] wake_cause, wake_act;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slp_wake_ctrl dut (.*);

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; halt_req = 0; clr_wdt = 0; ext_rst = 0; wdt_ovf = 0;
    pa_pin = '1; pc_pin = '1; pa_wken = '0; pc_wken = '0;
    irq_flag = '0; irq_en = '0; stack_full = 0;
    tick(2); rst_n = 1; tick(3);
  endtask

  task automatic go_sleep();
    halt_req = 1; tick(); halt_req = 0;
  endtask

  // ev: {pin, irq, wdt, ext}; expectation: cause, act, to, pd
  typedef struct packed {
    logic [3:0] ev; logic ien; logic sfull;
    logic [3:0] ecause; logic [3:0] eact; logic eto; logic epd;
  } vec_t;
  localparam vec_t VT [10] = '{
    '{4'b0001, 1'b0, 1'b0, 4'b0001, 4'b0001, 1'b0, 1'b0},  // R2
    '{4'b0010, 1'b0, 1'b0, 4'b0010, 4'b0010, 1'b1, 1'b1},  // R3
    '{4'b1000, 1'b0, 1'b0, 4'b1000, 4'b0100, 1'b0, 1'b1},  // R4
    '{4'b0100, 1'b1, 1'b0, 4'b0100, 4'b1000, 1'b0, 1'b1},  // R6
    '{4'b0100, 1'b0, 1'b0, 4'b0100, 4'b0100, 1'b0, 1'b1},  // R7 disabled
    '{4'b0100, 1'b1, 1'b1, 4'b0100, 4'b0100, 1'b0, 1'b1},  // R7 stack full
    '{4'b0011, 1'b0, 1'b0, 4'b0001, 4'b0001, 1'b0, 1'b0},  // R9 ext>wdt
    '{4'b0110, 1'b1, 1'b0, 4'b0010, 4'b0010, 1'b1, 1'b1},  // R9 wdt>irq
    '{4'b1100, 1'b1, 1'b0, 4'b0100, 4'b1000, 1'b0, 1'b1},  // R9 irq>pin
    '{4'b1111, 1'b1, 1'b0, 4'b0001, 4'b0001, 1'b0, 1'b0}   // R9 all
  };

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R11 reset asleep", asleep, 0);
    chk("R11 reset valid", wake_valid, 0);
    chk("R11 reset flags", {to_flag, pd_flag}, 0);

    for (int i = 0; i < 10; i++) begin
      do_reset();
      pa_wken = 8'h01; irq_en = {3'b0, VT[i].ien}; stack_full = VT[i].sfull;
      go_sleep();
      chk($sformatf("R1 v%0d asleep", i), asleep, 1);
      chk($sformatf("R1 v%0d pd", i), pd_flag, 1);
      ext_rst = VT[i].ev[0]; wdt_ovf = VT[i].ev[1]; irq_flag[0] = VT[i].ev[2];
      if (VT[i].ev[3]) pa_pin[0] = 0;
      if (VT[i].ev[2:0] != 0) tick(); else tick(3);
      ext_rst = 0; wdt_ovf = 0;
      chk($sformatf("R10 v%0d valid", i), wake_valid, 1);
      chk($sformatf("R9 v%0d cause", i), wake_cause, VT[i].ecause);
      chk($sformatf("R9 v%0d act", i), wake_act, VT[i].eact);
      chk($sformatf("R3 v%0d to", i), to_flag, VT[i].eto);
      chk($sformatf("R2 v%0d pd", i), pd_flag, VT[i].epd);
      chk($sformatf("R10 v%0d awake", i), asleep, 0);
      tick();
      chk($sformatf("R10 v%0d strobe ends", i), wake_valid, 0);
    end

    // R4 port C pin also wakes
    do_reset(); pc_wken = 8'h80; go_sleep();
    pc_pin[7] = 0; tick(2);
    chk("R4 pc not early", wake_valid, 0);
    tick();
    chk("R4 pc wake", {wake_valid, wake_cause}, 5'h18);

    // R5 disabled pin, rising edge, pre-low level
    do_reset(); pa_wken = 8'h01; pa_pin[0] = 0; tick(4);
    go_sleep(); pa_pin[1] = 0; tick(6);
    chk("R5 prelow/disabled stays asleep", asleep, 1);
    pa_pin[0] = 1; tick(6);
    chk("R5 rising stays asleep", asleep, 1);
    pa_pin[0] = 0; tick(3);
    chk("R5 then real edge wakes", wake_cause, 4'b1000);

    // R1 halt while asleep ignored
    do_reset(); go_sleep(); halt_req = 1; tick(); halt_req = 0;
    chk("R1 halt in sleep no wake", {asleep, wake_valid}, 2'b10);

    // R8 pending flag blocks
    do_reset(); irq_en = 4'hF; irq_flag[0] = 1; go_sleep(); tick(3);
    chk("R8 pending no wake", asleep, 1);
    irq_flag[0] = 0; tick(); irq_flag[0] = 1; tick(3);
    chk("R8 re-request no wake", asleep, 1);
    irq_flag[2] = 1; tick();
    chk("R8 other irq wakes", {wake_cause, wake_act}, 8'h48);

    // R11 clr_wdt after watchdog wake
    do_reset(); go_sleep(); wdt_ovf = 1; tick(); wdt_ovf = 0;
    chk("R3 to set", {to_flag, pd_flag}, 2'b11);
    clr_wdt = 1; tick(); clr_wdt = 0;
    chk("R11 clr_wdt clears", {to_flag, pd_flag}, 2'b00);

    // R2 ext reset while awake clears flags
    go_sleep(); wdt_ovf = 1; tick(); wdt_ovf = 0;
    ext_rst = 1; tick(); ext_rst = 0;
    chk("R2 awake ext clears", {to_flag, pd_flag, wake_valid}, 3'b000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule